// File: doc/BRIEF.md
# Acknowledge-terminated external bus read master

This block runs single read cycles on an external parallel bus on behalf of one internal requester. A read moves through six half-period states, S0 to S5. The block runs on an internal clock at twice the bus rate. A phase register splits each bus clock period into a rising half and a falling half, and the block drives the resulting bus clock out on `bus_clk`.

The cycle does not end after a fixed number of clocks. It ends when the slave pulls its acknowledge input low. Until then the master repeats pairs of wait states with every strobe and the address held. The acknowledge behaves the same whether logic inside the chip or an external device produces it. Read data is captured on the edge that sees the acknowledge low.

The strobes come off in two steps. Chip-select, byte-select and output-enable rise on the falling edge that opens S5. Address, size, the drive enable and transfer-in-progress are released on the next rising edge. That same rising edge can open S0 of the next read.

The request side is a valid/ready stream. The requester holds `req_valid`, `req_addr` and `req_siz` stable until a cycle where `req_ready` is high. `req_ready` is high only in two cases: when the block is idle in a falling half-period, and in S5. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse and the consumer must take `rsp_data` in that cycle.

Top module: `xrd_master`

## Requirements
- R1: After reset the block is idle. `bus_tip_n`, `bus_ts_n`, `bus_cs_n` and `bus_oe_n` are 1. `bus_bs_n` is all ones. `bus_drv` is 0, `bus_addr` is 0 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only when the block is idle in a falling half-period (`bus_clk`=0), or when it is in S5. On an accepted request the next cycle is S0, and in S0:
  - `bus_tip_n` and `bus_ts_n` are 0;
  - `bus_addr` and `bus_siz` carry the request;
  - `bus_rnw` is 1 (read) and `bus_drv` is 1;
  - `bus_clk` is 1.
- R3: `bus_ts_n` is low for exactly two internal cycles, S0 and S1, and is high from S2 onward.
- R4: `bus_cs_n` and `bus_oe_n` are low from S1 through S4. In those cycles `bus_bs_n` is low on the active byte lanes. Bit 3 is the lane at address offset 0 and bit 0 the lane at offset 3. The lanes depend on the size code:
  - size 01 (byte): the single lane at address bits [1:0] is active, so `bus_bs_n` = 4'b1111 with bit 3-offset cleared;
  - size 10 (word): lanes 3,2 are active when address bit 1 is 0, and lanes 1,0 when it is 1;
  - size 00 or 11: all four lanes are active.
- R5: `bus_ack_n` is sampled on the rising bus edge that ends S3. If it is high, the block returns to S2 and repeats S2 and S3, holding address, size and all strobes unchanged. So each wait adds two internal cycles, and S5 falls 5+2*waits cycles after S0.
- R6: `bus_din` is captured on the edge where `bus_ack_n` is sampled low. `rsp_valid` is 1 for exactly one cycle (S5) with `rsp_data` equal to the captured word.
- R7: In S5, `bus_cs_n`, `bus_oe_n` and `bus_bs_n` are high. `bus_tip_n` is still low and `bus_drv`, address and size are still driven. On the next edge, with no new request, `bus_tip_n` goes high, `bus_drv` goes to 0 and `bus_addr` goes to 0.
- R8: A request accepted in S5 starts S0 on the very next cycle. `bus_tip_n` stays low across the boundary, `bus_ts_n` falls, and the new address is presented.
- R9: `bus_clk` is 1 in S0, S2 and S4 and 0 in S1, S3 and S5. It alternates every internal cycle.
- R10: A low `bus_ack_n` during S1 or S2 has no effect. Only the value sampled at the end of S3 ends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus rate |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted on this edge if valid |
| req_addr | input | ADDR_W | Read address |
| req_siz | input | 2 | Size code: 00 long, 01 byte, 10 word, 11 line |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Captured read data |
| bus_clk | output | 1 | Bus clock, high in rising half-periods |
| bus_addr | output | ADDR_W | Bus address, 0 when not driven |
| bus_rnw | output | 1 | Read/write, 1 = read |
| bus_drv | output | 1 | Address, size and read/write are being driven |
| bus_tip_n | output | 1 | Transfer in progress, active low |
| bus_siz | output | 2 | Transfer size, 0 when not driven |
| bus_ts_n | output | 1 | Transfer start, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_bs_n | output | DATA_W/8 | Byte-lane selects, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_ack_n | input | 1 | Transfer acknowledge from the slave, active low |
| bus_din | input | DATA_W | Read data from the bus |

## Verification
Several rules hold on every cycle, and the assertions check them continuously:
- the transfer-start and select strobes stay inside transfer-in-progress;
- `req_ready` only appears in a falling half-period;
- address and size stay stable through wait states;
- the completion pulse lasts one cycle and comes two cycles after a low acknowledge;
- transfer-in-progress only rises right after that pulse.

Other behaviour depends on the slave's timing and on which request was issued, so only the bench scenarios can show it:
- the byte-lane pattern for each size and offset;
- the exact number of cycles added per wait state;
- that an early acknowledge pulse is ignored;
- that the data returned belongs to the matching request.

// File: rtl/xrd_pkg.sv
package xrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S0   = 3'd1,
    ST_S1   = 3'd2,
    ST_S2   = 3'd3,
    ST_S3   = 3'd4,
    ST_S4   = 3'd5,
    ST_S5   = 3'd6
  } xrd_state_t;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_LINE = 2'b11;

  // Byte-select window: S1 through S4 inclusive.
  function automatic logic in_select_window(input xrd_state_t s);
    return (s == ST_S1) || (s == ST_S2) || (s == ST_S3) || (s == ST_S4);
  endfunction

endpackage

// File: rtl/xrd_phase.sv
// Half-period tracker: the internal clock runs at twice the bus rate.
module xrd_phase (
  input  logic clk,
  input  logic rst,
  output logic ph_fall
);
  always_ff @(posedge clk) begin
    if (rst) ph_fall <= 1'b0;
    else     ph_fall <= ~ph_fall;
  end
endmodule

// File: rtl/xrd_lanes.sv
// Byte-lane decoder. Lane index LANES-1 is the lowest address offset.
module xrd_lanes #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] addr_lo,
  input  logic [1:0]       siz,
  output logic [LANES-1:0] sel
);
  import xrd_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] OFF_V = OFF_W'(LANES - 1 - i);
    assign sel[i] = (siz == SZ_BYTE) ? (addr_lo == OFF_V) :
                    (siz == SZ_WORD) ? (addr_lo[OFF_W-1:1] == OFF_V[OFF_W-1:1]) :
                                       1'b1;
  end
endmodule

// File: rtl/xrd_seq.sv
// State sequencer: S0..S5 with acknowledge-driven wait pairs.
module xrd_seq (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                ph_fall,
  input  logic                ack_n,
  output xrd_pkg::xrd_state_t state,
  output logic                req_ready,
  output logic                latch_en
);
  import xrd_pkg::*;

  xrd_state_t nxt;
  logic       fire;

  assign req_ready = ((state == ST_IDLE) && ph_fall) || (state == ST_S5);
  assign fire      = req_valid && req_ready;
  assign latch_en  = (state == ST_S3) && !ack_n;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (fire) nxt = ST_S0;
      ST_S0:   nxt = ST_S1;
      ST_S1:   nxt = ST_S2;
      ST_S2:   nxt = ST_S3;
      ST_S3:   nxt = ack_n ? ST_S2 : ST_S4;
      ST_S4:   nxt = ST_S5;
      ST_S5:   nxt = fire ? ST_S0 : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/xrd_master.sv
module xrd_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_siz,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_clk,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rnw,
  output logic              bus_drv,
  output logic              bus_tip_n,
  output logic [1:0]        bus_siz,
  output logic              bus_ts_n,
  output logic              bus_cs_n,
  output logic [LANES-1:0]  bus_bs_n,
  output logic              bus_oe_n,
  input  logic              bus_ack_n,
  input  logic [DATA_W-1:0] bus_din
);
  import xrd_pkg::*;

  logic              ph_fall;
  xrd_state_t        state;
  logic              latch_en;
  logic              active;
  logic              window;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        siz_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  lane_sel;

  xrd_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .ph_fall (ph_fall)
  );

  xrd_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ph_fall   (ph_fall),
    .ack_n     (bus_ack_n),
    .state     (state),
    .req_ready (req_ready),
    .latch_en  (latch_en)
  );

  xrd_lanes #(.LANES(LANES)) u_lanes (
    .addr_lo (addr_q[OFF_W-1:0]),
    .siz     (siz_q),
    .sel     (lane_sel)
  );

  // Request capture and read-data latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      siz_q  <= SZ_LONG;
      data_q <= '0;
    end else begin
      if (req_valid && req_ready) begin
        addr_q <= req_addr;
        siz_q  <= req_siz;
      end
      if (latch_en) data_q <= bus_din;
    end
  end

  assign active    = (state != ST_IDLE);
  assign window    = in_select_window(state);

  assign bus_clk   = ~ph_fall;
  assign bus_drv   = active;
  assign bus_tip_n = ~active;
  assign bus_addr  = active ? addr_q : '0;
  assign bus_siz   = active ? siz_q : 2'b00;
  assign bus_rnw   = 1'b1;
  assign bus_ts_n  = ~((state == ST_S0) || (state == ST_S1));
  assign bus_cs_n  = ~window;
  assign bus_oe_n  = ~window;
  assign bus_bs_n  = window ? ~lane_sel : '1;

  assign rsp_valid = (state == ST_S5);
  assign rsp_data  = data_q;
endmodule

// File: rtl/xrd_master_chk.sv
module xrd_master_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bus_clk,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz,
  input logic              bus_drv,
  input logic              bus_tip_n,
  input logic              bus_ts_n,
  input logic              bus_cs_n,
  input logic              bus_oe_n,
  input logic              bus_ack_n
);
  assert_ready_falling_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_clk);

  assert_ts_inside_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_ts_n |-> !bus_tip_n);

  assert_ts_fall_rising_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ts_n) |-> bus_clk);

  assert_select_inside_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_cs_n |-> (!bus_tip_n && !bus_oe_n && bus_drv));

  assert_hold_in_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (!bus_tip_n && $past(!bus_tip_n) && !$past(rsp_valid)) |->
      ($stable(bus_addr) && $stable(bus_siz)));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !$past(bus_ack_n, 2));

  assert_split_release_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (bus_cs_n && bus_oe_n && !bus_tip_n && bus_drv));

  assert_tip_end_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_tip_n) |-> $past(rsp_valid));

  assert_back_to_back_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && req_valid) |=> (!bus_tip_n && !bus_ts_n));
endmodule

bind xrd_master xrd_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bus_clk   (bus_clk),
  .bus_addr  (bus_addr),
  .bus_siz   (bus_siz),
  .bus_drv   (bus_drv),
  .bus_tip_n (bus_tip_n),
  .bus_ts_n  (bus_ts_n),
  .bus_cs_n  (bus_cs_n),
  .bus_oe_n  (bus_oe_n),
  .bus_ack_n (bus_ack_n)
);

// File: tb/xrd_master_test.sv
module xrd_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_siz = 2'b00;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        bus_clk, bus_rnw, bus_drv, bus_tip_n, bus_ts_n, bus_cs_n, bus_oe_n;
  logic [31:0] bus_addr;
  logic [1:0]  bus_siz;
  logic [3:0]  bus_bs_n;
  logic        bus_ack_n = 1'b1;
  logic [31:0] bus_din = '0;

  always #5 clk = ~clk;

  xrd_master uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_siz(req_siz), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_drv(bus_drv),
    .bus_tip_n(bus_tip_n), .bus_siz(bus_siz), .bus_ts_n(bus_ts_n), .bus_cs_n(bus_cs_n),
    .bus_bs_n(bus_bs_n), .bus_oe_n(bus_oe_n), .bus_ack_n(bus_ack_n), .bus_din(bus_din)
  );

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  siz;
    int          waits;
    bit          glitch;
  } item_t;

  item_t slv_q[$];
  item_t exp_q[$];
  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 0;

  function automatic logic [31:0] data_of(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[31:16]};
  endfunction

  function automatic logic [3:0] lanes_n(input logic [31:0] a, input logic [1:0] s);
    logic [3:0] v;
    v = 4'b0000;
    if (s == 2'b01) begin
      v = 4'b1111;
      v[3 - a[1:0]] = 1'b0;
    end else if (s == 2'b10) begin
      v = a[1] ? 4'b1100 : 4'b0011;
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // {tip_n, ts_n, cs_n, oe_n}
  task automatic chk_strobes(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {bus_tip_n, bus_ts_n, bus_cs_n, bus_oe_n};
    check(act == exp, req, 64'(act), 64'(exp));
  endtask

  // Slave model: acknowledge after 2+2*waits select cycles, optional early pulse.
  int    scnt = 0;
  item_t cur;
  always @(negedge clk) begin
    if (rst || bus_cs_n) begin
      scnt = 0;
      bus_ack_n = 1'b1;
      bus_din = 32'h0;
    end else begin
      if (scnt == 0) begin
        if (slv_q.size() == 0) begin
          check(1'b0, "R2 unexpected select", 64'(bus_addr), 64'h0);
          cur = '{addr: bus_addr, siz: bus_siz, waits: 0, glitch: 1'b0};
        end else begin
          cur = slv_q.pop_front();
        end
        check(bus_addr == cur.addr, "R2 address", 64'(bus_addr), 64'(cur.addr));
        check(bus_bs_n == lanes_n(cur.addr, cur.siz), "R4 byte lanes",
              64'(bus_bs_n), 64'(lanes_n(cur.addr, cur.siz)));
      end
      bus_ack_n = !((cur.glitch && scnt < 2) || (scnt >= 2 + 2 * cur.waits));
      bus_din   = (scnt >= 2 + 2 * cur.waits) ? data_of(bus_addr) : ~data_of(bus_addr);
      scnt++;
    end
  end

  // Monitor / scoreboard.
  int mcnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!bus_tip_n && !bus_ts_n && bus_clk) mcnt = 0;
      else mcnt++;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected response", 64'(rsp_data), 64'h0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(rsp_data == data_of(e.addr), "R6 read data", 64'(rsp_data), 64'(data_of(e.addr)));
          check(mcnt == 5 + 2 * e.waits, e.glitch ? "R10 early ack ignored" : "R5 wait timing",
                64'(mcnt), 64'(5 + 2 * e.waits));
        end
      end
    end
  end

  task automatic push_item(input logic [31:0] a, input logic [1:0] s, input int w, input bit g);
    item_t it;
    it = '{addr: a, siz: s, waits: w, glitch: g};
    slv_q.push_back(it);
    exp_q.push_back(it);
  endtask

  // Driver: called at a negedge, returns at the negedge after acceptance (S0).
  task automatic issue(input logic [31:0] a, input logic [1:0] s, input int w, input bit g);
    push_item(a, s, w, g);
    req_addr  = a;
    req_siz   = s;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk_strobes("R1 strobes in reset", 4'b1111);
    check(bus_bs_n == 4'b1111 && !bus_drv && bus_addr == 0 && !rsp_valid,
          "R1 idle bus", 64'({bus_bs_n, bus_drv, rsp_valid}), 64'({4'b1111, 2'b00}));
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk_strobes("R1 strobes after reset", 4'b1111);

    // Directed read: word at offset 2, one wait pair.
    push_item(32'h1000_0002, 2'b10, 1, 1'b0);
    req_addr = 32'h1000_0002; req_siz = 2'b10; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    check(!bus_clk, "R2 ready only in falling half", 64'(bus_clk), 64'h0);
    @(negedge clk); req_valid = 1'b0;
    // S0
    chk_strobes("R2 S0 strobes", 4'b0011);
    check(bus_addr == 32'h1000_0002 && bus_siz == 2'b10 && bus_rnw && bus_drv,
          "R2 S0 address/size", 64'(bus_addr), 64'h1000_0002);
    check(bus_clk == 1'b1, "R9 S0 rising half", 64'(bus_clk), 64'h1);
    @(negedge clk); // S1
    chk_strobes("R3 S1 start still low", 4'b0000);
    check(bus_bs_n == 4'b1100, "R4 word offset 2 lanes", 64'(bus_bs_n), 64'hC);
    check(bus_clk == 1'b0, "R9 S1 falling half", 64'(bus_clk), 64'h0);
    @(negedge clk); // S2
    chk_strobes("R3 S2 start released", 4'b0100);
    check(!req_ready, "R2 not ready mid-cycle", 64'(req_ready), 64'h0);
    @(negedge clk); // S3
    chk_strobes("R4 S3 selects", 4'b0100);
    @(negedge clk); // wait S2
    chk_strobes("R5 wait strobes held", 4'b0100);
    check(bus_addr == 32'h1000_0002 && !rsp_valid, "R5 wait address held", 64'(bus_addr), 64'h1000_0002);
    @(negedge clk); // S3
    @(negedge clk); // S4
    chk_strobes("R4 S4 selects", 4'b0100);
    check(!rsp_valid, "R6 no pulse before S5", 64'(rsp_valid), 64'h0);
    @(negedge clk); // S5
    chk_strobes("R7 S5 selects released", 4'b0111);
    check(bus_bs_n == 4'b1111 && bus_drv && bus_addr == 32'h1000_0002,
          "R7 S5 address still driven", 64'(bus_addr), 64'h1000_0002);
    check(rsp_valid, "R6 pulse in S5", 64'(rsp_valid), 64'h1);
    @(negedge clk); // idle
    chk_strobes("R7 released after S5", 4'b1111);
    check(!bus_drv && bus_addr == 0 && !rsp_valid, "R7 address released", 64'(bus_addr), 64'h0);

    // R8: back-to-back pair
    repeat (3) @(negedge clk);
    issue(32'h0000_0100, 2'b00, 0, 1'b0);
    issue(32'h0000_0205, 2'b01, 2, 1'b0);
    chk_strobes("R8 back-to-back S0", 4'b0011);
    check(bus_addr == 32'h0000_0205, "R8 new address", 64'(bus_addr), 64'h205);

    // R10: early acknowledge pulse, then mixed sizes and gaps.
    issue(32'h0000_3000, 2'b10, 1, 1'b1);
    issue(32'h0000_4003, 2'b01, 3, 1'b0);
    issue(32'h0000_5000, 2'b11, 0, 1'b0);
    for (int i = 0; i < 24; i++) begin
      if (i % 5 == 0) repeat (3) @(negedge clk);
      issue(32'h2000_0000 + 32'(i * 7), 2'(i % 4), i % 4, (i % 3 == 0) && (i % 4 != 0));
    end

    begin
      int guard = 0;
      while ((exp_q.size() != 0 || !bus_tip_n) && guard < 200) begin
        @(negedge clk);
        guard++;
      end
    end
    check(exp_q.size() == 0, "R6 all responses returned", 64'(exp_q.size()), 64'h0);
    chk_strobes("R1 idle at end", 4'b1111);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule